// File: doc/BRIEF.md
# Security Interrupt Status Aggregator

This block gathers level status lines from a set of peripheral protection controllers, memory protection controllers and expansion memory-side checkers, and packs them into 32-bit words that software reads through simple register strobes. Protection-controller lines land at fixed bit slots that are deliberately non-contiguous: internal APB controllers at the bottom, APB expansion controllers from bit 4, AHB expansion controllers from bit 20. The block also holds the enable words that are fanned out as per-controller enable levels.

Clearing works differently from a local write-one-to-clear register. A write to a clear register does not change any status bit. It drives per-source clear lines back to the originating controllers, which then drop their own status lines. The checker group also has an enable word, a non-secure selection word fanned out to per-checker lines, and one combined, registered interrupt. A bridge-error pair is included: its status always reads zero and its enable keeps only the upper half-word.

Top module: `sec_irq_agg`

## Requirements
- R1: The controller status word at address 0x0 places controller input index i at bit i for the 2 internal APB controllers, at bit 4+(i-2) for the 4 APB expansion controllers, and at bit 20+(i-6) for the 4 AHB expansion controllers. The word reflects the inputs one clock after they are driven. All other bits read 0.
- R2: A write to the controller enable register (address 0x1) stores the data ANDed with 0x00F000F3. A read returns the stored value.
- R3: Each ctl_en_o[i] equals the enable-register bit at controller i's status-word position. It changes only on an enable write.
- R4: A write to the controller clear register (address 0x2) loads each ctl_clr_o[i] with controller i's bit of the status word as it reads at that moment. The level is held until the next clear write. The register reads as 0.
- R5: The memory-controller status word at address 0x3 holds the internal inputs at bits 0 upward and the expansion inputs at bits 16 upward.
- R6: The checker status word at address 0x4 holds checker input j at bit 16+j. chk_irq_o is 1 exactly when that word ANDed with the checker enable word (address 0x5, full 32-bit read/write) is non-zero.
- R7: A write to the checker clear register (address 0x6) loads chk_clr_o[j] from bit 16+j of the written data and holds it until the next such write. The register reads as 0.
- R8: The checker non-secure register (address 0x7) stores all 32 written bits. chk_ns_o[j] equals its bit 16+j.
- R9: The bridge status register (address 0x8) always reads 0. The bridge enable register (address 0x9) stores the data ANDed with 0xFFFF0000.
- R10: After reset, every register reads 0 and every output is 0.
- R11: chk_irq_o is registered. It takes its new value on the same clock edge at which a changed checker status input or a checker enable write becomes visible in the read data.
- R12: Writes to read-only addresses (0x0, 0x3, 0x4, 0x8) and to the unused addresses 0xA to 0xF have no effect. Reads of unused addresses return 0. Read data appears on rdata_o one clock after the rd_en_i cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register select |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after rd_en_i |
| ctl_stat_i | input | 10 | Protection-controller status lines (APB internal, APB expansion, AHB expansion) |
| ctl_en_o | output | 10 | Per-controller interrupt enable levels |
| ctl_clr_o | output | 10 | Per-controller interrupt clear levels |
| mem_stat_i | input | 4 | Internal memory-controller status lines |
| mem_exp_stat_i | input | 4 | Expansion memory-controller status lines |
| chk_stat_i | input | 4 | Expansion checker status lines |
| chk_clr_o | output | 4 | Per-checker clear levels |
| chk_ns_o | output | 4 | Per-checker non-secure selection |
| chk_irq_o | output | 1 | Combined checker interrupt |

## Verification
The bench builds the block with its default parameters: two internal APB controllers, and four of each expansion controller, memory-controller and checker group. Every slot of every group is populated, so the highest bit of each gap-separated range (bits 7, 23 and 19) and the unused bits between ranges are all exercised. Random status patterns and register writes run against a bench-side model of the packing and masking. Directed cases cover the all-ones enable mask, the irq timing edge, and writes to read-only and unused addresses.

// File: rtl/sec_irq_pkg.sv
package sec_irq_pkg;
  localparam logic [3:0] A_CTL_STAT = 4'h0;
  localparam logic [3:0] A_CTL_EN   = 4'h1;
  localparam logic [3:0] A_CTL_CLR  = 4'h2;
  localparam logic [3:0] A_MEM_STAT = 4'h3;
  localparam logic [3:0] A_CHK_STAT = 4'h4;
  localparam logic [3:0] A_CHK_EN   = 4'h5;
  localparam logic [3:0] A_CHK_CLR  = 4'h6;
  localparam logic [3:0] A_CHK_NS   = 4'h7;
  localparam logic [3:0] A_BRG_STAT = 4'h8;
  localparam logic [3:0] A_BRG_EN   = 4'h9;

  localparam int APB_EXP_BASE = 4;
  localparam int AHB_EXP_BASE = 20;
  localparam int EXP_BASE     = 16;

  // status-word bit position of controller i
  function automatic int ctl_pos(input int i, input int n_int, input int n_apb_exp);
    if (i < n_int) return i;
    else if (i < n_int + n_apb_exp) return APB_EXP_BASE + (i - n_int);
    else return AHB_EXP_BASE + (i - n_int - n_apb_exp);
  endfunction

  function automatic logic [31:0] ctl_mask(input int n_int, input int n_apb_exp, input int n_ahb_exp);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < n_int + n_apb_exp + n_ahb_exp; i++) m[ctl_pos(i, n_int, n_apb_exp)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/sia_ctl_bank.sv
module sia_ctl_bank #(
  parameter int N_APB_INT = 2,
  parameter int N_APB_EXP = 4,
  parameter int N_AHB_EXP = 4,
  parameter int DW        = 32,
  localparam int NC       = N_APB_INT + N_APB_EXP + N_AHB_EXP
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NC-1:0] stat_i,
  input  logic          en_we_i,
  input  logic          clr_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] stat_word_o,
  output logic [DW-1:0] en_word_o,
  output logic [NC-1:0] en_o,
  output logic [NC-1:0] clr_o
);
  import sec_irq_pkg::*;
  localparam logic [DW-1:0] MASK = DW'(ctl_mask(N_APB_INT, N_APB_EXP, N_AHB_EXP));

  logic [DW-1:0] stat_d, stat_q, en_q;
  logic [NC-1:0] clr_q, clr_d;

  always_comb begin
    stat_d = '0;
    for (int i = 0; i < NC; i++) stat_d[ctl_pos(i, N_APB_INT, N_APB_EXP)] = stat_i[i];
  end

  for (genvar g = 0; g < NC; g++) begin : g_ctl
    localparam int P = ctl_pos(g, N_APB_INT, N_APB_EXP);
    assign en_o[g]  = en_q[P];
    assign clr_d[g] = stat_q[P];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
      clr_q  <= '0;
    end else begin
      stat_q <= stat_d;
      if (en_we_i)  en_q  <= wdata_i & MASK;
      if (clr_we_i) clr_q <= clr_d;
    end
  end

  assign stat_word_o = stat_q;
  assign en_word_o   = en_q;
  assign clr_o       = clr_q;
endmodule

// File: rtl/sia_mem_stat.sv
module sia_mem_stat #(
  parameter int N_MEM_INT = 4,
  parameter int N_MEM_EXP = 4,
  parameter int DW        = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_MEM_INT-1:0] int_i,
  input  logic [N_MEM_EXP-1:0] exp_i,
  output logic [DW-1:0]        word_o
);
  import sec_irq_pkg::*;
  logic [DW-1:0] d;

  always_comb begin
    d = '0;
    d[N_MEM_INT-1:0] = int_i;
    d[EXP_BASE +: N_MEM_EXP] = exp_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_o <= '0;
    else         word_o <= d;
  end
endmodule

// File: rtl/sia_chk_bank.sv
module sia_chk_bank #(
  parameter int N_CHK = 4,
  parameter int DW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CHK-1:0] stat_i,
  input  logic             en_we_i,
  input  logic             clr_we_i,
  input  logic             ns_we_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    stat_word_o,
  output logic [DW-1:0]    en_word_o,
  output logic [DW-1:0]    ns_word_o,
  output logic [N_CHK-1:0] clr_o,
  output logic [N_CHK-1:0] ns_o,
  output logic             irq_o
);
  import sec_irq_pkg::*;
  logic [DW-1:0] stat_d, stat_q, en_d, en_q, ns_q;
  logic [N_CHK-1:0] clr_q;
  logic irq_q;

  always_comb begin
    stat_d = '0;
    stat_d[EXP_BASE +: N_CHK] = stat_i;
    en_d = en_we_i ? wdata_i : en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
      ns_q   <= '0;
      clr_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
      irq_q  <= |(stat_d & en_d);  // next-state values: irq moves with the visible words
      if (ns_we_i)  ns_q  <= wdata_i;
      if (clr_we_i) clr_q <= wdata_i[EXP_BASE +: N_CHK];
    end
  end

  assign stat_word_o = stat_q;
  assign en_word_o   = en_q;
  assign ns_word_o   = ns_q;
  assign ns_o        = ns_q[EXP_BASE +: N_CHK];
  assign clr_o       = clr_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/sec_irq_agg.sv
module sec_irq_agg #(
  parameter int N_APB_INT = 2,
  parameter int N_APB_EXP = 4,
  parameter int N_AHB_EXP = 4,
  parameter int N_MEM_INT = 4,
  parameter int N_MEM_EXP = 4,
  parameter int N_CHK     = 4,
  parameter int DW        = 32,
  parameter int AW        = 4,
  localparam int NC       = N_APB_INT + N_APB_EXP + N_AHB_EXP
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic [NC-1:0]        ctl_stat_i,
  output logic [NC-1:0]        ctl_en_o,
  output logic [NC-1:0]        ctl_clr_o,
  input  logic [N_MEM_INT-1:0] mem_stat_i,
  input  logic [N_MEM_EXP-1:0] mem_exp_stat_i,
  input  logic [N_CHK-1:0]     chk_stat_i,
  output logic [N_CHK-1:0]     chk_clr_o,
  output logic [N_CHK-1:0]     chk_ns_o,
  output logic                 chk_irq_o
);
  import sec_irq_pkg::*;
  localparam logic [DW-1:0] BRG_MASK = {{(DW/2){1'b1}}, {(DW - DW/2){1'b0}}};

  logic [DW-1:0] ctl_stat_w, ctl_en_w, mem_w, chk_stat_w, chk_en_w, chk_ns_w;
  logic [DW-1:0] brg_en_q, rd_mux, rdata_q;

  logic [3:0] sel;
  assign sel = 4'(addr_i);

  sia_ctl_bank #(.N_APB_INT(N_APB_INT), .N_APB_EXP(N_APB_EXP), .N_AHB_EXP(N_AHB_EXP), .DW(DW)) u_ctl (
    .clk_i, .rst_ni,
    .stat_i     (ctl_stat_i),
    .en_we_i    (wr_en_i && sel == A_CTL_EN),
    .clr_we_i   (wr_en_i && sel == A_CTL_CLR),
    .wdata_i    (wdata_i),
    .stat_word_o(ctl_stat_w),
    .en_word_o  (ctl_en_w),
    .en_o       (ctl_en_o),
    .clr_o      (ctl_clr_o)
  );

  sia_mem_stat #(.N_MEM_INT(N_MEM_INT), .N_MEM_EXP(N_MEM_EXP), .DW(DW)) u_mem (
    .clk_i, .rst_ni,
    .int_i (mem_stat_i),
    .exp_i (mem_exp_stat_i),
    .word_o(mem_w)
  );

  sia_chk_bank #(.N_CHK(N_CHK), .DW(DW)) u_chk (
    .clk_i, .rst_ni,
    .stat_i     (chk_stat_i),
    .en_we_i    (wr_en_i && sel == A_CHK_EN),
    .clr_we_i   (wr_en_i && sel == A_CHK_CLR),
    .ns_we_i    (wr_en_i && sel == A_CHK_NS),
    .wdata_i    (wdata_i),
    .stat_word_o(chk_stat_w),
    .en_word_o  (chk_en_w),
    .ns_word_o  (chk_ns_w),
    .clr_o      (chk_clr_o),
    .ns_o       (chk_ns_o),
    .irq_o      (chk_irq_o)
  );

  always_comb begin
    unique case (sel)
      A_CTL_STAT: rd_mux = ctl_stat_w;
      A_CTL_EN:   rd_mux = ctl_en_w;
      A_MEM_STAT: rd_mux = mem_w;
      A_CHK_STAT: rd_mux = chk_stat_w;
      A_CHK_EN:   rd_mux = chk_en_w;
      A_CHK_NS:   rd_mux = chk_ns_w;
      A_BRG_EN:   rd_mux = brg_en_q;
      default:    rd_mux = '0;  // clear regs, bridge status, unused
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brg_en_q <= '0;
      rdata_q  <= '0;
    end else begin
      if (wr_en_i && sel == A_BRG_EN) brg_en_q <= wdata_i & BRG_MASK;
      if (rd_en_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/sia_chk_sva.sv
module sia_chk_sva #(
  parameter int N_APB_INT = 2,
  parameter int N_APB_EXP = 4,
  parameter int N_AHB_EXP = 4,
  parameter int N_CHK     = 4,
  parameter int DW        = 32,
  parameter int AW        = 4,
  localparam int NC       = N_APB_INT + N_APB_EXP + N_AHB_EXP
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic [DW-1:0]    rdata_o,
  input logic [NC-1:0]    ctl_en_o,
  input logic [NC-1:0]    ctl_clr_o,
  input logic [N_CHK-1:0] chk_clr_o,
  input logic             chk_irq_o
);
  import sec_irq_pkg::*;
  localparam logic [DW-1:0] MASK = DW'(ctl_mask(N_APB_INT, N_APB_EXP, N_AHB_EXP));

  // R2
  ctl_en_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && 4'(addr_i) == A_CTL_EN) |=> (rdata_o & ~MASK) == '0);

  // R3
  ctl_en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && 4'(addr_i) == A_CTL_EN) |=> $stable(ctl_en_o));

  // R4
  ctl_clr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && 4'(addr_i) == A_CTL_CLR) |=> $stable(ctl_clr_o));

  // R7
  chk_clr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && 4'(addr_i) == A_CHK_CLR) |=> $stable(chk_clr_o));

  // R6
  chk_irq_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && 4'(addr_i) == A_CHK_EN && wdata_i == '0) |=> !chk_irq_o);

  // R9
  brg_stat_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && 4'(addr_i) == A_BRG_STAT) |=> rdata_o == '0);

  // R12
  unused_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && 4'(addr_i) > A_BRG_EN) |=> rdata_o == '0);
endmodule

bind sec_irq_agg sia_chk_sva #(
  .N_APB_INT(N_APB_INT), .N_APB_EXP(N_APB_EXP), .N_AHB_EXP(N_AHB_EXP),
  .N_CHK(N_CHK), .DW(DW), .AW(AW)
) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .ctl_en_o(ctl_en_o), .ctl_clr_o(ctl_clr_o), .chk_clr_o(chk_clr_o),
  .chk_irq_o(chk_irq_o)
);

// File: tb/sim_sec_irq_agg.sv
`timescale 1ns/1ps
module sim_sec_irq_agg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [9:0] ctl_stat = '0, ctl_en, ctl_clr;
  logic [3:0] mem_stat = '0, mem_exp = '0, chk_stat = '0, chk_clr, chk_ns;
  logic chk_irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // model state
  logic [31:0] m_ctl_en, m_chk_en, m_chk_ns, m_brg_en;
  logic [9:0]  m_ctl_clr;
  logic [3:0]  m_chk_clr;

  always #2 clk = ~clk;

  sec_irq_agg u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ctl_stat_i(ctl_stat), .ctl_en_o(ctl_en),
    .ctl_clr_o(ctl_clr), .mem_stat_i(mem_stat), .mem_exp_stat_i(mem_exp),
    .chk_stat_i(chk_stat), .chk_clr_o(chk_clr), .chk_ns_o(chk_ns), .chk_irq_o(chk_irq)
  );

  function automatic int pos(input int i);
    if (i < 2) return i;
    if (i < 6) return i + 2;
    return i + 14;
  endfunction

  function automatic logic [31:0] ctl_word(input logic [9:0] s);
    logic [31:0] w = '0;
    for (int i = 0; i < 10; i++) w[pos(i)] = s[i];
    return w;
  endfunction

  function automatic logic [9:0] ctl_pick(input logic [31:0] w);
    logic [9:0] v;
    for (int i = 0; i < 10; i++) v[i] = w[pos(i)];
    return v;
  endfunction

  function automatic logic [31:0] mem_word(input logic [3:0] a, input logic [3:0] b);
    return {12'h0, b, 12'h0, a};
  endfunction

  function automatic logic [31:0] chk_word(input logic [3:0] s);
    return {12'h0, s, 16'h0};
  endfunction

  function automatic logic [31:0] expect_rd(input logic [3:0] a);
    case (a)
      4'h0: return ctl_word(ctl_stat);
      4'h1: return m_ctl_en;
      4'h3: return mem_word(mem_stat, mem_exp);
      4'h4: return chk_word(chk_stat);
      4'h5: return m_chk_en;
      4'h7: return m_chk_ns;
      4'h9: return m_brg_en;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    tick();
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    // model: clear levels sample the status word before the edge
    case (a)
      4'h1: m_ctl_en = d & 32'h00F000F3;
      4'h2: m_ctl_clr = ctl_pick(ctl_word(ctl_stat));
      4'h5: m_chk_en = d;
      4'h6: m_chk_clr = d[19:16];
      4'h7: m_chk_ns = d;
      4'h9: m_brg_en = d & 32'hFFFF0000;
      default: ;
    endcase
    tick();
    wr_en = 1'b0;
  endtask

  task automatic check_outputs(input string tag);
    chk({"R3 ctl_en ", tag}, 32'(ctl_en), 32'(ctl_pick(m_ctl_en)));
    chk({"R4 ctl_clr ", tag}, 32'(ctl_clr), 32'(m_ctl_clr));
    chk({"R7 chk_clr ", tag}, 32'(chk_clr), 32'(m_chk_clr));
    chk({"R8 chk_ns ", tag}, 32'(chk_ns), 32'(m_chk_ns[19:16]));
    chk({"R6 chk_irq ", tag}, 32'(chk_irq), 32'(|(chk_word(chk_stat) & m_chk_en)));
  endtask

  task automatic check_all_regs(input string tag);
    logic [31:0] d;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk($sformatf("R12 reg %0h %s", a, tag), d, expect_rd(4'(a)));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EC1A9));
    m_ctl_en = '0; m_chk_en = '0; m_chk_ns = '0; m_brg_en = '0;
    m_ctl_clr = '0; m_chk_clr = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 ctl_en", 32'(ctl_en), 0);
    chk("R10 chk_irq", 32'(chk_irq), 0);
    chk("R10 rdata", rdata, 0);
    rst_n = 1'b1;
    tick();
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk($sformatf("R10 reg %0h", a), d, 32'h0);
    end

    // R2 mask with all ones
    wr(4'h1, 32'hFFFFFFFF);
    rd(4'h1, d);
    chk("R2 enable mask", d, 32'h00F000F3);
    chk("R3 all enables", 32'(ctl_en), 32'h3FF);
    // R9 bridge
    wr(4'h9, 32'hFFFFFFFF);
    rd(4'h9, d); chk("R9 bridge enable mask", d, 32'hFFFF0000);
    rd(4'h8, d); chk("R9 bridge status", d, 32'h0);

    // R1 highest slots of each group
    ctl_stat = 10'b1000100010; tick();
    rd(4'h0, d); chk("R1 group tops", d, 32'h00800082);
    // R4 clear samples status word
    wr(4'h2, 32'h0);
    chk("R4 clear from status", 32'(ctl_clr), 32'(10'b1000100010));
    rd(4'h2, d); chk("R4 clear reads zero", d, 32'h0);

    // R12 writes to read-only and unused addresses
    wr(4'h0, 32'hFFFFFFFF); wr(4'h4, 32'hFFFFFFFF); wr(4'h8, 32'hFFFFFFFF);
    wr(4'hA, 32'hFFFFFFFF); wr(4'hF, 32'hFFFFFFFF);
    check_all_regs("ro write");
    check_outputs("ro write");

    // R11 irq timing
    wr(4'h5, 32'h00080000);
    chk("R11 irq idle", 32'(chk_irq), 0);
    chk_stat = 4'b1000;
    @(posedge clk); #1;
    chk("R11 irq same edge", 32'(chk_irq), 1);
    @(negedge clk);
    chk_stat = 4'b0000;
    @(posedge clk); #1;
    chk("R11 irq drop", 32'(chk_irq), 0);
    @(negedge clk);
    chk_stat = 4'b0100; tick();
    chk("R6 disabled bit", 32'(chk_irq), 0);

    // R7 R8 directed
    wr(4'h6, 32'h000A5555);
    chk("R7 clr from data", 32'(chk_clr), 32'hA);
    wr(4'h7, 32'h1234FFFF);
    chk("R8 ns lines", 32'(chk_ns), 32'h4);

    // random mix
    for (int it = 0; it < 300; it++) begin
      ctl_stat = 10'($urandom); mem_stat = 4'($urandom);
      mem_exp = 4'($urandom); chk_stat = 4'($urandom);
      tick();
      wr(4'($urandom), $urandom);
      check_outputs($sformatf("it %0d", it));
      rd(4'($urandom_range(0, 9)), d);
      chk($sformatf("R1 R5 R6 rand read it %0d", it), d, expect_rd(addr));
      if (it % 50 == 0) check_all_regs($sformatf("it %0d", it));
    end
    rd(4'h3, d); chk("R5 mem word", d, mem_word(mem_stat, mem_exp));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule